// File: doc/BRIEF.md
# Four-Slot Program Bank Selector

This block splits a 32 KiB CPU program window into four 8 KiB slots and picks the physical ROM bank that each slot shows. The slots begin at CPU addresses 0x8000, 0xA000, 0xC000 and 0xE000. Two writable bank registers and a swap flag set the mapping. The last slot always shows the final bank of the ROM. The slot at 0xC000 shows the second-to-last bank unless the swap flag moves it. The block also holds a one-bit nametable mirroring select.

The CPU writes through a strobe with an address and a data byte. The physical bank number of each slot and the mirroring select come straight from the registered state. A surrounding address path uses them to form ROM addresses. The total bank count is a parameter and must be a power of two, so any register value reduces to a bank that exists.

Top module: `prg_slot_map`

## Requirements
- R1: While reset is held and right after it ends, slot 0 and slot 1 show bank 0, slot 2 shows bank BANK_COUNT-2, slot 3 shows bank BANK_COUNT-1, and the mirroring select is 0.
- R2: A write is decoded on the address ANDed with 0xF003. A decoded 0x8000 loads bank register A and a decoded 0xA000 loads bank register B, so for example 0x8FFC also loads register A.
- R3: With swap off, slot 0 shows register A, slot 1 shows register B, slot 2 shows bank BANK_COUNT-2 and slot 3 shows bank BANK_COUNT-1.
- R4: A write to decoded 0x9001 with any nonzero data, for example 0x80, turns swap on. A write of 0x00 turns it off.
- R5: With swap on, slot 0 shows bank BANK_COUNT-2 and slot 2 shows register A.
- R6: Slot 1 and slot 3 show the same banks whether swap is on or off.
- R7: A write to decoded 0x9000 sets the mirroring select to data bit 0 (1 = horizontal, 0 = vertical). The other data bits are ignored.
- R8: A bank register keeps its data value modulo BANK_COUNT. With 32 banks, 0x25 gives bank 5 and 0xFF gives bank 31.
- R9: A write changes the outputs on the clock edge that samples the strobe, and not earlier. With the strobe low, no output changes.
- R10: A write to any other decoded address leaves every output unchanged. Examples are 0x8001, 0x9002, 0xB000, 0xC000, 0xF001 and 0x7000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | ADDR_W | CPU write address |
| wr_data | input | DATA_W | CPU write data |
| slot0_bank | output | BANK_W | Physical bank for 0x8000-0x9FFF |
| slot1_bank | output | BANK_W | Physical bank for 0xA000-0xBFFF |
| slot2_bank | output | BANK_W | Physical bank for 0xC000-0xDFFF |
| slot3_bank | output | BANK_W | Physical bank for 0xE000-0xFFFF |
| mirror_horiz | output | 1 | Mirroring select: 1 horizontal, 0 vertical |

## Verification
The outputs are combinational from the state, so any wrong register value shows on a slot output in the same cycle it is captured. A bad swap flag shows as slot 0 and slot 2 trading places, while slot 1 stays put. A decode that is too loose or too tight shows one cycle after the stray write, as a changed output or one that failed to change. The bench therefore compares all five outputs with a behavioural model on every clock.

// File: rtl/prg_slot_map.sv
module prg_slot_map #(
  parameter int BANK_COUNT = 32,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  localparam int BANK_W    = $clog2(BANK_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [BANK_W-1:0] slot0_bank,
  output logic [BANK_W-1:0] slot1_bank,
  output logic [BANK_W-1:0] slot2_bank,
  output logic [BANK_W-1:0] slot3_bank,
  output logic              mirror_horiz
);

  localparam logic [ADDR_W-1:0] DEC_MASK   = ADDR_W'('hF003);
  localparam logic [ADDR_W-1:0] SEL_A      = ADDR_W'('h8000);
  localparam logic [ADDR_W-1:0] SEL_B      = ADDR_W'('hA000);
  localparam logic [ADDR_W-1:0] SEL_MIR    = ADDR_W'('h9000);
  localparam logic [ADDR_W-1:0] SEL_SWAP   = ADDR_W'('h9001);
  localparam logic [BANK_W-1:0] BANK_PENULT = BANK_W'(BANK_COUNT - 2);
  localparam logic [BANK_W-1:0] BANK_FINAL  = BANK_W'(BANK_COUNT - 1);

  logic [ADDR_W-1:0] dec_addr;
  logic              hit_a, hit_b, hit_mir, hit_swap;
  logic [BANK_W-1:0] bank_a_q, bank_b_q;
  logic              swap_q, mir_q;

  assign dec_addr = wr_addr & DEC_MASK;
  assign hit_a    = wr_en && (dec_addr == SEL_A);
  assign hit_b    = wr_en && (dec_addr == SEL_B);
  assign hit_mir  = wr_en && (dec_addr == SEL_MIR);
  assign hit_swap = wr_en && (dec_addr == SEL_SWAP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_a_q <= '0;
      bank_b_q <= '0;
      swap_q   <= 1'b0;
      mir_q    <= 1'b0;
    end else begin
      if (hit_a)    bank_a_q <= wr_data[BANK_W-1:0];
      if (hit_b)    bank_b_q <= wr_data[BANK_W-1:0];
      if (hit_swap) swap_q   <= |wr_data;
      if (hit_mir)  mir_q    <= wr_data[0];
    end
  end

  assign slot0_bank   = swap_q ? BANK_PENULT : bank_a_q;
  assign slot1_bank   = bank_b_q;
  assign slot2_bank   = swap_q ? bank_a_q : BANK_PENULT;
  assign slot3_bank   = BANK_FINAL;
  assign mirror_horiz = mir_q;

  p_reg_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_a |=> (slot0_bank == $past(wr_data[BANK_W-1:0])) ||
              (slot2_bank == $past(wr_data[BANK_W-1:0])));

  p_reg_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_b |=> slot1_bank == $past(wr_data[BANK_W-1:0]));

  p_swap_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_swap && (wr_data != '0)) |=> slot0_bank == BANK_PENULT);

  p_swap_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_swap && (wr_data == '0)) |=> slot2_bank == BANK_PENULT);

  p_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_mir |=> mirror_horiz == $past(wr_data[0]));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(slot0_bank) && $stable(slot1_bank) &&
               $stable(slot2_bank) && $stable(mirror_horiz));

endmodule

// File: tb/prg_slot_map_tb.sv
`timescale 1ns/1ps
module prg_slot_map_tb;
  localparam int N  = 32;
  localparam int BW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [15:0]   wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [BW-1:0] s0, s1, s2, s3;
  logic          mir;

  int checks = 0;
  int fails  = 0;
  int m_a = 0, m_b = 0, m_swap = 0, m_mir = 0;

  always #4 clk = ~clk;

  prg_slot_map #(.BANK_COUNT(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .slot0_bank(s0), .slot1_bank(s1), .slot2_bank(s2), .slot3_bank(s3),
    .mirror_horiz(mir));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "slot0", int'(s0), m_swap ? N-2 : m_a);
    chk(tag, "slot1", int'(s1), m_b);
    chk(tag, "slot2", int'(s2), m_swap ? m_a : N-2);
    chk(tag, "slot3", int'(s3), N-1);
    chk(tag, "mirror", int'(mir), m_mir);
  endtask

  task automatic model_step(input bit en, input int addr, input int data, input bit rst);
    if (rst) begin
      m_a = 0; m_b = 0; m_swap = 0; m_mir = 0;
    end else if (en) begin
      case (addr & 'hF003)
        'h8000: m_a = data % N;
        'hA000: m_b = data % N;
        'h9001: m_swap = (data != 0);
        'h9000: m_mir = data % 2;
        default: ;
      endcase
    end
  endtask

  task automatic cyc(input bit en, input int addr, input int data, input string tag);
    wr_en = en; wr_addr = 16'(addr); wr_data = 8'(data);
    @(posedge clk);
    #1 model_step(en, addr, data, !rst_n);
    @(negedge clk);
    compare(tag);
    wr_en = 1'b0;
  endtask

  task automatic wr(input int addr, input int data, input string tag);
    cyc(1'b1, addr, data, tag);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    wr_en = 1'b1; wr_addr = 16'h8000; wr_data = 8'h07;
    cyc(1'b1, 'h8000, 7, "R1 during reset");
    rst_n = 1'b1;
    cyc(1'b0, 0, 0, "R1 after reset");

    wr('h8000, 3, "R2 R3 reg A");
    wr('hA000, 5, "R2 R3 reg B");
    cyc(1'b0, 0, 0, "R9 idle");
    wr('h8FFC, 7, "R2 masked alias");
    wr('hBFFE & 'hA000, 9, "R2 reg B again");

    wr('h9001, 'h80, "R4 R5 R6 swap on");
    wr('h8000, 11, "R5 reg A under swap");
    wr('hA000, 12, "R6 reg B under swap");
    wr('h9001, 0, "R4 R6 swap off");
    wr('h9001, 1, "R4 swap on bit0");
    wr('h9001, 0, "R4 swap off again");

    wr('h9000, 'hFE, "R7 mirror bit0 clear");
    wr('h9000, 'h01, "R7 mirror horizontal");
    wr('h9000, 'hFD, "R7 mirror upper bits");
    wr('h9000, 'h03, "R7 mirror set");

    wr('h8000, 'h25, "R8 wrap A");
    wr('hA000, 'hFF, "R8 wrap B");

    wr('h8001, 1, "R10 0x8001");
    wr('h9002, 1, "R10 0x9002");
    wr('hB000, 1, "R10 0xB000");
    wr('hC000, 1, "R10 0xC000");
    wr('hF001, 2, "R10 0xF001");
    wr('h7000, 1, "R10 0x7000");
    cyc(1'b0, 'h8000, 2, "R9 strobe low");
    cyc(1'b0, 'h9001, 1, "R9 strobe low swap");

    for (int i = 0; i < 40; i++) begin
      int a;
      a = (i % 4 == 0) ? 'h8000 : (i % 4 == 1) ? 'hA000 : (i % 4 == 2) ? 'h9001 : 'h9000;
      wr(a | ((i * 4) & 'h0FFC), (i * 37 + 5) % 256, "R3 R5 mixed");
    end

    wr('h9001, 'h10, "R5 swap before reset");
    rst_n = 1'b0;
    cyc(1'b0, 0, 0, "R1 second reset");
    rst_n = 1'b1;
    cyc(1'b0, 0, 0, "R1 after second reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule